// File: doc/BRIEF.md
# Keyed Shutdown and Wake-up Controller

This block sits in the always-on slow-clock domain. It drives a single shutdown output that gates the main power of the chip. Software enters shutdown by writing a command word that carries an 8-bit password. Any other write to the command location has no effect, so a stray store cannot power the chip down.

While the chip is shut down, the block watches sixteen external wake pins and two internal alarm inputs from the real-time clock and the real-time timer. Each pin has its own enable and its own active level. Each pin passes through a two-flop synchronizer and then a debounce counter. All pins share one debounce length. A source that qualifies clears the shutdown output and sets a sticky cause flag. After power returns, firmware reads the cause word to learn why the chip woke. That read also clears the word.

The register port is a plain strobe interface. A write or a read is accepted in any cycle in which its strobe is high, so there is no back-pressure. Read data is combinational from the address. A status read clears the flags on the clock edge that ends the read cycle.

Top module: `keyed_shutdown_ctrl`

## Requirements
- R1: A write to offset 0x00 with bit 0 = 1 and bits 31:24 = 0xA5 sets `shdn_o` high on the clock edge that accepts the write.
- R2: A write to offset 0x00 leaves `shdn_o` unchanged if it has any other key or if bit 0 = 0. Offset 0x00 reads as zero.
- R3: Offset 0x04 keeps the debounce select in bits 26:24, the RTC alarm enable in bit 17 and the RTT alarm enable in bit 16. All its other bits read zero. Offset 0x0C reads back all 32 bits that were written. Bits 15:0 of 0x0C enable the pins one per bit, and bits 31:16 set each pin's level (1 = active high, 0 = active low). Unmapped offsets read zero.
- R4: Debounce selects 0 to 5 give hold lengths N = 0, 3, 32, 512, 4096 and 32768 cycles. Selects 6 and 7 act as 5. The pin must change between clock edges, with the chip shut down, and then stay at its active level. `shdn_o` is still high after N+2 edges and is low after edge N+3.
- R5: An enabled pin that leaves its active level before it qualifies restarts its count from zero.
- R6: The polarity bit of a pin selects its active level. A pin whose enable bit is 0 never causes a wake.
- R7: While shut down, an enabled RTC alarm input at 1 clears `shdn_o` on the next edge and sets status bit 5. An enabled RTT alarm does the same and sets status bit 4.
- R8: Status bits 31:16 flag the pins, one bit per pin. Every source that qualifies on the same edge is flagged. After reset the status reads zero, which marks a plain power-on.
- R9: Status flags stay set until a read of offset 0x08. That read returns the flags and clears them on the same edge.
- R10: While `shdn_o` is low, the alarm and pin inputs set no flag and change nothing.
- R11: At reset all registers clear, `shdn_o` is low and every offset reads zero.
- R12: With zero written to offsets 0x04 and 0x0C, no pin and no alarm can end a shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; a status read clears the flags |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| wake_pin_i | input | NUM_WAKE | External wake pins, asynchronous |
| rtc_alarm_i | input | 1 | RTC alarm, synchronous to `clk` |
| rtt_alarm_i | input | 1 | RTT alarm, synchronous to `clk` |
| shdn_o | output | 1 | Shutdown request, high while powered down |

## Verification
The case that is hardest to reach from the ports is the exact edge on which a debounced pin qualifies. That edge depends on the synchronizer delay plus the hold length, and it shifts when a short pulse has reset the count. The stimulus changes a pin just after a falling edge and counts rising edges from that point. It checks the output one edge before the expected release and again on the release edge. It does this for several selects and both polarities. It also sends a pulse that is too short before the long hold, and it runs one alias select through the full 32768-cycle window.

// File: rtl/shdn_pkg.sv
package shdn_pkg;

  localparam int REG_W      = 32;
  localparam int DBC_CNT_W  = 16;

  localparam int OFS_CTRL   = 'h0;
  localparam int OFS_MODE   = 'h4;
  localparam int OFS_STAT   = 'h8;
  localparam int OFS_WCFG   = 'hC;

  localparam logic [7:0] CMD_KEY = 8'hA5;
  localparam int KEY_LSB      = 24;
  localparam int CMD_BIT      = 0;
  localparam int DBC_LSB      = 24;
  localparam int RTC_EN_BIT   = 17;
  localparam int RTT_EN_BIT   = 16;
  localparam int PIN_FLAG_LSB = 16;
  localparam int POL_LSB      = 16;
  localparam int RTC_FLAG_BIT = 5;
  localparam int RTT_FLAG_BIT = 4;

  typedef struct packed {
    logic [2:0] dbc_sel;
    logic       rtc_en;
    logic       rtt_en;
  } mode_t;

  // Hold length for each debounce select; the upper codes alias the longest.
  function automatic logic [DBC_CNT_W-1:0] dbc_limit(input logic [2:0] sel);
    logic [DBC_CNT_W-1:0] lim;
    case (sel)
      3'd0:    lim = DBC_CNT_W'(0);
      3'd1:    lim = DBC_CNT_W'(3);
      3'd2:    lim = DBC_CNT_W'(32);
      3'd3:    lim = DBC_CNT_W'(512);
      3'd4:    lim = DBC_CNT_W'(4096);
      default: lim = DBC_CNT_W'(32768);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/shdn_sync2.sv
module shdn_sync2 #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;

endmodule

// File: rtl/shdn_debounce.sv
module shdn_debounce #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             qual_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || !active_i) begin
      cnt_q <= '0;
    end else if (cnt_q < limit_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o = run_i && active_i && (cnt_q >= limit_i);

  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (cnt_q == '0)); // R5

  AST_IDLE_WHEN_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !qual_o); // R10

endmodule

// File: rtl/shdn_wake_unit.sv
module shdn_wake_unit
  import shdn_pkg::*;
#(
  parameter int NUM_WAKE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAKE-1:0] pins_i,
  input  logic [NUM_WAKE-1:0] en_i,
  input  logic [NUM_WAKE-1:0] pol_i,
  input  logic [2:0]          dbc_sel_i,
  input  logic                asleep_i,
  output logic [NUM_WAKE-1:0] qual_o
);

  logic [NUM_WAKE-1:0]  synced;
  logic [NUM_WAKE-1:0]  active;
  logic [DBC_CNT_W-1:0] limit;

  shdn_sync2 #(.WIDTH(NUM_WAKE)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_i),
    .sync_o  (synced)
  );

  assign active = ~(synced ^ pol_i);
  assign limit  = dbc_limit(dbc_sel_i);

  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_pin
    shdn_debounce #(.CNT_W(DBC_CNT_W)) u_dbc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (asleep_i && en_i[g]),
      .active_i (active[g]),
      .limit_i  (limit),
      .qual_o   (qual_o[g])
    );
  end

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((qual_o & ~en_i) == '0)); // R6

endmodule

// File: rtl/keyed_shutdown_ctrl.sv
module keyed_shutdown_ctrl
  import shdn_pkg::*;
#(
  parameter int NUM_WAKE = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_WAKE-1:0] wake_pin_i,
  input  logic                rtc_alarm_i,
  input  logic                rtt_alarm_i,
  output logic                shdn_o
);

  logic                shdn_q;
  mode_t               mode_q;
  logic [NUM_WAKE-1:0] wen_q;
  logic [NUM_WAKE-1:0] wpol_q;
  logic [NUM_WAKE-1:0] flag_pin_q;
  logic                flag_rtc_q;
  logic                flag_rtt_q;

  logic                hit_ctrl, hit_mode, hit_stat, hit_wcfg;
  logic                cmd_ok;
  logic [NUM_WAKE-1:0] pin_qual;
  logic                rtc_hit, rtt_hit, wake_any, stat_clear;

  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_mode = (addr_i == ADDR_W'(OFS_MODE));
  assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));
  assign hit_wcfg = (addr_i == ADDR_W'(OFS_WCFG));

  assign cmd_ok = wr_en_i && hit_ctrl && wdata_i[CMD_BIT] &&
                  (wdata_i[KEY_LSB +: 8] == CMD_KEY);

  shdn_wake_unit #(.NUM_WAKE(NUM_WAKE)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_i    (wake_pin_i),
    .en_i      (wen_q),
    .pol_i     (wpol_q),
    .dbc_sel_i (mode_q.dbc_sel),
    .asleep_i  (shdn_q),
    .qual_o    (pin_qual)
  );

  assign rtc_hit    = shdn_q && mode_q.rtc_en && rtc_alarm_i;
  assign rtt_hit    = shdn_q && mode_q.rtt_en && rtt_alarm_i;
  assign wake_any   = (|pin_qual) || rtc_hit || rtt_hit;
  assign stat_clear = rd_en_i && hit_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shdn_q <= 1'b0;
    end else if (wake_any) begin
      shdn_q <= 1'b0;
    end else if (cmd_ok) begin
      shdn_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      wen_q  <= '0;
      wpol_q <= '0;
    end else if (wr_en_i) begin
      if (hit_mode) begin
        mode_q.dbc_sel <= wdata_i[DBC_LSB +: 3];
        mode_q.rtc_en  <= wdata_i[RTC_EN_BIT];
        mode_q.rtt_en  <= wdata_i[RTT_EN_BIT];
      end
      if (hit_wcfg) begin
        wen_q  <= wdata_i[NUM_WAKE-1:0];
        wpol_q <= wdata_i[POL_LSB +: NUM_WAKE];
      end
    end
  end

  // New causes win over a clearing read in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_pin_q <= '0;
      flag_rtc_q <= 1'b0;
      flag_rtt_q <= 1'b0;
    end else if (stat_clear) begin
      flag_pin_q <= pin_qual;
      flag_rtc_q <= rtc_hit;
      flag_rtt_q <= rtt_hit;
    end else begin
      flag_pin_q <= flag_pin_q | pin_qual;
      flag_rtc_q <= flag_rtc_q | rtc_hit;
      flag_rtt_q <= flag_rtt_q | rtt_hit;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_mode) begin
      rdata_o[DBC_LSB +: 3]  = mode_q.dbc_sel;
      rdata_o[RTC_EN_BIT]    = mode_q.rtc_en;
      rdata_o[RTT_EN_BIT]    = mode_q.rtt_en;
    end else if (hit_stat) begin
      rdata_o[PIN_FLAG_LSB +: NUM_WAKE] = flag_pin_q;
      rdata_o[RTC_FLAG_BIT]             = flag_rtc_q;
      rdata_o[RTT_FLAG_BIT]             = flag_rtt_q;
    end else if (hit_wcfg) begin
      rdata_o[NUM_WAKE-1:0]         = wen_q;
      rdata_o[POL_LSB +: NUM_WAKE]  = wpol_q;
    end
  end

  assign shdn_o = shdn_q;

  AST_KEYED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shdn_q) |-> $past(wr_en_i && hit_ctrl && wdata_i[CMD_BIT] &&
                            (wdata_i[KEY_LSB +: 8] == CMD_KEY))); // R1

  AST_WAKE_LEAVES_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shdn_q) |-> ((|flag_pin_q) || flag_rtc_q || flag_rtt_q)); // R8

  AST_FLAGS_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(flag_pin_q & ~$past(flag_pin_q))) || (flag_rtc_q && !$past(flag_rtc_q)) ||
     (flag_rtt_q && !$past(flag_rtt_q))) |-> $past(shdn_q)); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clear && !shdn_q) |=> (!(|flag_pin_q) && !flag_rtc_q && !flag_rtt_q)); // R9

endmodule

// File: tb/keyed_shutdown_ctrl_test.sv
module keyed_shutdown_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [15:0] pins = '0;
  logic        rtc = 1'b0;
  logic        rtt = 1'b0;
  logic        shdn;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyed_shutdown_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
    .wake_pin_i(pins), .rtc_alarm_i(rtc), .rtt_alarm_i(rtt), .shdn_o(shdn)
  );

  function automatic int hold_len(input int sel);
    case (sel)
      0: return 0;
      1: return 3;
      2: return 32;
      3: return 512;
      4: return 4096;
      default: return 32768;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Configure one enabled pin, shut down, drive it active, check release edge.
  task automatic pin_case(input int idx, input logic pol, input int sel);
    logic [31:0] r;
    logic [15:0] polm;
    int n;
    polm = 16'($urandom());
    polm[idx] = pol;
    n = hold_len(sel);
    wr(4'hC, {polm, 16'(1 << idx)});
    wr(4'h4, 32'(sel) << 24);
    pins = ~polm;
    idle(3);
    wr(4'h0, 32'hA500_0001);
    chk("R1 shutdown entry", {31'd0, shdn}, 32'd1);
    @(negedge clk);
    pins[idx] = pol;
    idle(n + 2);
    chk("R4 still down one edge early", {31'd0, shdn}, 32'd1);
    idle(1);
    chk("R4 released on edge N+3", {31'd0, shdn}, 32'd0);
    pins = ~polm;
    rd(4'h8, r);
    chk("R8 pin cause flag", r, 32'h1 << (16 + idx));
    rd(4'h8, r);
    chk("R9 cleared by read", r, 32'd0);
  endtask

  initial begin
    logic [31:0] r, m, w;
    logic [3:0] a;
    void'($urandom(32'd2718));

    idle(2);
    chk("R11 shdn at reset", {31'd0, shdn}, 32'd0);
    rst_n = 1'b1;
    rd(4'h0, r); chk("R11 ctrl reset", r, 32'd0);
    rd(4'h4, r); chk("R11 mode reset", r, 32'd0);
    rd(4'h8, r); chk("R8 power-on status zero", r, 32'd0);
    rd(4'hC, r); chk("R11 wake cfg reset", r, 32'd0);

    wr(4'h0, 32'hA400_0001); chk("R2 wrong key", {31'd0, shdn}, 32'd0);
    wr(4'h0, 32'hA500_0000); chk("R2 key without command", {31'd0, shdn}, 32'd0);
    wr(4'h0, 32'h5A00_0001); chk("R2 inverted key", {31'd0, shdn}, 32'd0);
    rd(4'h0, r); chk("R2 ctrl reads zero", r, 32'd0);

    for (int i = 0; i < 16; i++) begin
      m = $urandom(); w = $urandom();
      wr(4'h4, m); rd(4'h4, r); chk("R3 mode readback", r, m & 32'h0703_0000);
      wr(4'hC, w); rd(4'hC, r); chk("R3 wake cfg readback", r, w);
      a = 4'($urandom());
      if (a[1:0] == 2'b00) a[0] = 1'b1;
      rd(a, r); chk("R3 unmapped reads zero", r, 32'd0);
    end

    // Alarms while awake do nothing
    wr(4'hC, 32'h0);
    wr(4'h4, 32'h0003_0000);
    @(negedge clk); rtc = 1'b1; rtt = 1'b1;
    idle(10);
    rtc = 1'b0; rtt = 1'b0;
    chk("R10 awake stays awake", {31'd0, shdn}, 32'd0);
    rd(4'h8, r); chk("R10 no flag while awake", r, 32'd0);

    // Debounced pin wakes, both polarities
    pin_case($urandom_range(0, 15), 1'b0, 0);
    pin_case($urandom_range(0, 15), 1'b1, 1);
    pin_case($urandom_range(0, 15), 1'b0, 2);
    pin_case($urandom_range(0, 15), 1'b1, 3);
    pin_case(15, 1'b1, 0);
    pin_case(0, 1'b0, 1);
    pin_case($urandom_range(0, 15), 1'($urandom()), 6);

    // R5: short pulse restarts count
    wr(4'hC, 32'h0008_0008);
    wr(4'h4, 32'h0200_0000);
    pins = '0; idle(3);
    wr(4'h0, 32'hA500_0001);
    @(negedge clk); pins[3] = 1'b1;
    idle(10); pins[3] = 1'b0;
    idle(5);
    chk("R5 short pulse ignored", {31'd0, shdn}, 32'd1);
    pins[3] = 1'b1;
    idle(32 + 2);
    chk("R5 restarted count not done", {31'd0, shdn}, 32'd1);
    idle(1);
    chk("R5 restarted count releases", {31'd0, shdn}, 32'd0);
    pins = '0;
    rd(4'h8, r); chk("R5 cause after restart", r, 32'h0008_0000);

    // R6: disabled pin never wakes
    wr(4'hC, 32'hFFFF_0001);
    wr(4'h4, 32'h0);
    pins = '0; idle(3);
    wr(4'h0, 32'hA500_0001);
    @(negedge clk); pins[9] = 1'b1;
    idle(40);
    chk("R6 disabled pin no wake", {31'd0, shdn}, 32'd1);
    pins = '0;

    // R12: zeroed config blocks every source
    wr(4'h4, 32'h0);
    wr(4'hC, 32'h0);
    @(negedge clk); rtc = 1'b1; rtt = 1'b1; pins = 16'hFFFF;
    idle(10); pins = '0; idle(10);
    chk("R12 still down", {31'd0, shdn}, 32'd1);
    rtc = 1'b0; rtt = 1'b0;
    rd(4'h8, r); chk("R12 no flags", r, 32'd0);

    // R7: RTC alarm
    wr(4'h4, 32'h0002_0000);
    @(negedge clk); rtc = 1'b1;
    @(negedge clk); rtc = 1'b0;
    chk("R7 rtc wakes next edge", {31'd0, shdn}, 32'd0);
    rd(4'h8, r); chk("R7 rtc flag bit 5", r, 32'h20);

    // R7: RTT alarm
    wr(4'h4, 32'h0001_0000);
    wr(4'h0, 32'hA500_0001);
    chk("R1 re-entry", {31'd0, shdn}, 32'd1);
    @(negedge clk); rtt = 1'b1;
    @(negedge clk); rtt = 1'b0;
    chk("R7 rtt wakes next edge", {31'd0, shdn}, 32'd0);
    rd(4'h8, r); chk("R7 rtt flag bit 4", r, 32'h10);

    // R8/R9: simultaneous sources, sticky flags
    wr(4'h4, 32'h0003_0000);
    wr(4'h0, 32'hA500_0001);
    @(negedge clk); rtc = 1'b1; rtt = 1'b1;
    @(negedge clk); rtc = 1'b0; rtt = 1'b0;
    chk("R8 joint wake", {31'd0, shdn}, 32'd0);
    idle(20);
    rd(4'h8, r); chk("R8 both flags sticky", r, 32'h30);
    rd(4'h8, r); chk("R9 second read zero", r, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule